// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block decides which interrupt a small 8-bit processor services next. It watches five request lines. The first is a non-maskable line that always wins. Next come three vectored restart lines, each of which software can mask on its own. The last is a general request that has no vector and the lowest priority. A global interrupt enable gates every request except the non-maskable one. Software changes that enable with set and clear strobes. The block samples its request lines only on a strobe that marks the end of an instruction. One clock later it reports the chosen request as a one-cycle take pulse that carries the request's vector. When the general request is the one chosen, it also raises an acknowledge.

Software sees the block through two words. The set-mask word loads the three restart mask bits, and it can update a serial output pin from its top bit. The read-mask word always shows the mask bits, the global enable, the levels of the three restart lines, and the serial input pin in its top bit. Instruction fetch, stacking of the return address and the jump to the vector belong to the processor.

Top module: `intc_top`

## Requirements
- R1: When `instrDone` is high and `trapIn` is high, the next cycle shows `intTake`=1 and `intVector`=0x24, with `intAck`=0. This holds whatever the global enable and the mask bits are, and the global enable is left unchanged.
- R2: Restart line i is eligible only while mask bit i is 0. Mask bit 0 belongs to `restartIn[0]`, bit 1 to `restartIn[1]` and bit 2 to `restartIn[2]`. A line whose mask bit is 1 is never taken.
- R3: Among eligible restart lines, `restartIn[2]` beats `restartIn[1]`, which beats `restartIn[0]`. The vector of line i is 0x2C + 8*i, which gives 0x2C, 0x34 and 0x3C. Any restart line beats the general request, and `trapIn` beats all of them.
- R4: Requests are evaluated only in a cycle with `instrDone`=1. The take, vector and acknowledge outputs are registered and valid in the following cycle only. In every other cycle `intTake`, `intAck` and `intVector` are 0.
- R5: When nothing of higher priority is taken, the global enable is 1 and `genReqIn` is high at `instrDone`, the next cycle shows `intTake`=1, `intAck`=1 and `intVector`=0x00.
- R6: Taking a restart or general request clears the global enable. Otherwise `enableClr` clears it and `enableSet` sets it. When both strobes are high together, clear wins. With the enable at 0, only `trapIn` can be taken.
- R7: `maskRdData` is bit 7 = `serIn`, bits 6:4 = `restartIn[2:0]`, bit 3 = global enable, and bits 2:0 = mask bits. It follows its inputs in the same cycle and follows register changes from the clock edge on which they happen.
- R8: A `maskWrEn` cycle loads `maskWrData[2:0]` into the mask only if `maskWrData[3]`=1. It loads `maskWrData[7]` into `serOut` only if `maskWrData[6]`=1. Each field is left untouched when its control bit is 0.
- R9: Reset (`rstN` low) clears the global enable, the mask bits, `serOut` and all take outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trapIn | input | 1 | Non-maskable request |
| restartIn | input | 3 | Vectored maskable restart requests |
| genReqIn | input | 1 | General maskable request, no vector |
| instrDone | input | 1 | Instruction boundary strobe |
| enableSet | input | 1 | Set the global interrupt enable |
| enableClr | input | 1 | Clear the global interrupt enable |
| maskWrEn | input | 1 | Set-mask write strobe |
| maskWrData | input | 8 | Set-mask word |
| serIn | input | 1 | Serial input pin |
| maskRdData | output | 8 | Read-mask word |
| serOut | output | 1 | Serial output pin |
| intTake | output | 1 | One-cycle pulse: a request was accepted |
| intVector | output | 8 | Vector of the accepted request |
| intAck | output | 1 | Acknowledge of the general request |

## Verification
The take, vector and acknowledge outputs are due one clock after the `instrDone` edge, so the bench samples them just after that edge. It checks them again one cycle later to confirm that the pulse has ended. The enable and mask registers also change on the edge that samples their strobes. They are checked through `maskRdData` after that same edge, while `maskRdData`'s request and serial-input fields are compared in the cycle their inputs are applied. The sweep covers every combination of non-maskable request, restart levels, general request, mask value and global enable, which is 512 cases. A model in the bench computes the expected result of each case from the priority rules.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int RST_N    = 3;
  localparam int RIDX_W   = $clog2(RST_N);
  localparam int WORD_W   = 8;

  typedef struct packed {
    logic              take;
    logic              trap;
    logic              rstHit;
    logic [RIDX_W-1:0] rstIdx;
    logic              gen;
    logic              ieSet;
    logic              ieClr;
    logic              maskLoad;
    logic              serLoad;
  } ctrlStrobes_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrDone,
  input  logic             trapIn,
  input  logic [RST_N-1:0] restartIn,
  input  logic             genReqIn,
  input  logic             enableSet,
  input  logic             enableClr,
  input  logic             maskWrEn,
  input  logic             maskCtl,
  input  logic             serCtl,
  input  logic             ieQ,
  input  logic [RST_N-1:0] maskQ,
  output ctrlStrobes_t     st
);
  logic [RST_N-1:0] eligible;
  logic             maskableTake;

  assign eligible = restartIn & ~maskQ;

  always_comb begin
    st = '0;
    if (instrDone) begin
      if (trapIn) begin
        st.trap = 1'b1;
      end else if (ieQ) begin
        // ascending scan: the highest eligible index is kept
        for (int i = 0; i < RST_N; i++) begin
          if (eligible[i]) begin
            st.rstHit = 1'b1;
            st.rstIdx = RIDX_W'(i);
          end
        end
        if (!st.rstHit) st.gen = genReqIn;
      end
    end
    st.take     = st.trap | st.rstHit | st.gen;
    maskableTake = st.rstHit | st.gen;
    st.ieClr    = maskableTake | enableClr;
    st.ieSet    = enableSet & ~st.ieClr;
    st.maskLoad = maskWrEn & maskCtl;
    st.serLoad  = maskWrEn & serCtl;
  end

  // R3: at most one source is selected per boundary
  a_r3_one_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.trap, st.rstHit, st.gen}));

  // R4: nothing is selected away from an instruction boundary
  a_r4_boundary_only: assert property (@(posedge clk) disable iff (!rstN)
    !instrDone |-> !st.take);

  // R2: a masked line is never selected
  a_r2_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    st.rstHit |-> !maskQ[st.rstIdx] && restartIn[st.rstIdx]);
endmodule

// File: rtl/intc_dpath.sv
module intc_dpath
  import intc_pkg::*;
#(
  parameter logic [WORD_W-1:0] TRAP_VEC = 8'h24,
  parameter logic [WORD_W-1:0] VEC_BASE = 8'h2C,
  parameter int                VEC_STEP = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      st,
  input  logic [RST_N-1:0]  maskIn,
  input  logic              serBit,
  input  logic [RST_N-1:0]  restartIn,
  input  logic              serIn,
  output logic              ieQ,
  output logic [RST_N-1:0]  maskQ,
  output logic              serOutQ,
  output logic [WORD_W-1:0] rdWord,
  output logic              takeQ,
  output logic [WORD_W-1:0] vecQ,
  output logic              ackQ
);
  logic [WORD_W-1:0] nextVec;

  always_comb begin
    nextVec = '0;
    if (st.trap)        nextVec = TRAP_VEC;
    else if (st.rstHit) nextVec = VEC_BASE + WORD_W'(VEC_STEP) * WORD_W'(st.rstIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieQ     <= 1'b0;
      maskQ   <= '0;
      serOutQ <= 1'b0;
      takeQ   <= 1'b0;
      vecQ    <= '0;
      ackQ    <= 1'b0;
    end else begin
      if (st.ieClr)      ieQ <= 1'b0;
      else if (st.ieSet) ieQ <= 1'b1;
      if (st.maskLoad) maskQ   <= maskIn;
      if (st.serLoad)  serOutQ <= serBit;
      takeQ <= st.take;
      vecQ  <= nextVec;
      ackQ  <= st.gen;
    end
  end

  assign rdWord = {serIn, restartIn, ieQ, maskQ};

  // R6: an accepted maskable request leaves the enable cleared
  a_r6_ie_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (st.rstHit || st.gen) |=> !ieQ);

  // R1: the non-maskable path does not disturb the enable
  a_r1_ie_kept: assert property (@(posedge clk) disable iff (!rstN)
    (st.trap && !st.ieClr && !st.ieSet) |=> $stable(ieQ));

  // R8: the serial output only moves on a gated write
  a_r8_serout_hold: assert property (@(posedge clk) disable iff (!rstN)
    !st.serLoad |=> $stable(serOutQ));

  // R8: the mask only moves on a gated write
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !st.maskLoad |=> $stable(maskQ));
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             trapIn,
  input  logic [2:0]       restartIn,
  input  logic             genReqIn,
  input  logic             instrDone,
  input  logic             enableSet,
  input  logic             enableClr,
  input  logic             maskWrEn,
  input  logic [7:0]       maskWrData,
  input  logic             serIn,
  output logic [7:0]       maskRdData,
  output logic             serOut,
  output logic             intTake,
  output logic [7:0]       intVector,
  output logic             intAck
);
  ctrlStrobes_t     st;
  logic             ieQ;
  logic [RST_N-1:0] maskQ;
  logic [1:0]       unusedWrBits;

  assign unusedWrBits = maskWrData[5:4];

  intc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instrDone (instrDone),
    .trapIn    (trapIn),
    .restartIn (restartIn),
    .genReqIn  (genReqIn),
    .enableSet (enableSet),
    .enableClr (enableClr),
    .maskWrEn  (maskWrEn),
    .maskCtl   (maskWrData[3]),
    .serCtl    (maskWrData[6]),
    .ieQ       (ieQ),
    .maskQ     (maskQ),
    .st        (st)
  );

  intc_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .maskIn    (maskWrData[2:0]),
    .serBit    (maskWrData[7]),
    .restartIn (restartIn),
    .serIn     (serIn),
    .ieQ       (ieQ),
    .maskQ     (maskQ),
    .serOutQ   (serOut),
    .rdWord    (maskRdData),
    .takeQ     (intTake),
    .vecQ      (intVector),
    .ackQ      (intAck)
  );

  // R1: the non-maskable request wins at any boundary
  a_r1_trap_first: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && trapIn) |=> intTake && intVector == 8'h24 && !intAck);

  // R5: acknowledge only accompanies a take with a zero vector
  a_r5_ack_general: assert property (@(posedge clk) disable iff (!rstN)
    intAck |-> intTake && intVector == 8'h00);

  // R4: no outputs one cycle after a non-boundary cycle
  a_r4_idle_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !instrDone |=> !intTake && !intAck && intVector == 8'h00);
endmodule

// File: tb/intc_top_tb.sv
module intc_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       trapIn = 1'b0;
  logic [2:0] restartIn = '0;
  logic       genReqIn = 1'b0;
  logic       instrDone = 1'b0;
  logic       enableSet = 1'b0;
  logic       enableClr = 1'b0;
  logic       maskWrEn = 1'b0;
  logic [7:0] maskWrData = '0;
  logic       serIn = 1'b0;
  logic [7:0] maskRdData;
  logic       serOut;
  logic       intTake;
  logic [7:0] intVector;
  logic       intAck;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_top u_dut (
    .clk(clk), .rstN(rstN), .trapIn(trapIn), .restartIn(restartIn),
    .genReqIn(genReqIn), .instrDone(instrDone), .enableSet(enableSet),
    .enableClr(enableClr), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .serIn(serIn), .maskRdData(maskRdData), .serOut(serOut),
    .intTake(intTake), .intVector(intVector), .intAck(intAck)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nFails++;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R9: reset state
    chk("R9 rdword", {24'd0, maskRdData}, 32'h00);
    chk("R9 serOut", {31'd0, serOut}, 0);
    chk("R9 take", {31'd0, intTake}, 0);
    rstN = 1'b1;
    step();
    chk("R9 rdword after release", {24'd0, maskRdData}, 32'h00);

    // R1 R2 R3 R5 R6 R7: full sweep
    for (int c = 0; c < 512; c++) begin
      logic       t, g, ie, expTake, expAck, expIe;
      logic [2:0] r, m;
      logic [7:0] expVec;
      t = c[0]; r = c[3:1]; g = c[4]; m = c[7:5]; ie = c[8];
      maskWrEn = 1'b1; maskWrData = {4'b0000, 1'b1, m};
      enableSet = ie; enableClr = ~ie;
      step();
      maskWrEn = 1'b0; maskWrData = '0; enableSet = 1'b0; enableClr = 1'b0;
      trapIn = t; restartIn = r; genReqIn = g; instrDone = 1'b1;
      #1;
      chk("R7 rdword", {24'd0, maskRdData}, {24'd0, 1'b0, r, ie, m});
      expTake = 1'b0; expAck = 1'b0; expVec = 8'h00; expIe = ie;
      if (t) begin
        expTake = 1'b1; expVec = 8'h24;
      end else if (ie) begin
        for (int i = 0; i < 3; i++)
          if (r[i] && !m[i]) begin expTake = 1'b1; expVec = 8'h2C + 8'(8 * i); end
        if (!expTake && g) begin expTake = 1'b1; expAck = 1'b1; end
        if (expTake) expIe = 1'b0;
      end
      step();
      trapIn = 1'b0; restartIn = '0; genReqIn = 1'b0; instrDone = 1'b0;
      #1;
      chk("R1/R3 take", {31'd0, intTake}, {31'd0, expTake});
      chk("R3 vector", {24'd0, intVector}, {24'd0, expVec});
      chk("R5 ack", {31'd0, intAck}, {31'd0, expAck});
      chk("R6 enable after", {31'd0, maskRdData[3]}, {31'd0, expIe});
      chk("R2 mask kept", {29'd0, maskRdData[2:0]}, {29'd0, m});
      step();
      chk("R4 pulse ends", {31'd0, intTake}, 0);
    end

    // R4: request held high without boundary strobe
    enableSet = 1'b1; step(); enableSet = 1'b0;
    trapIn = 1'b1; genReqIn = 1'b1; restartIn = 3'b111;
    step(); step();
    chk("R4 no take off boundary", {31'd0, intTake}, 0);
    chk("R4 no ack off boundary", {31'd0, intAck}, 0);
    trapIn = 1'b0; genReqIn = 1'b0; restartIn = '0;

    // R6: clear wins over set
    enableSet = 1'b1; enableClr = 1'b1; step();
    enableSet = 1'b0; enableClr = 1'b0;
    chk("R6 clear wins", {31'd0, maskRdData[3]}, 0);

    // R8: serial output gated by bit 6, mask gated by bit 3
    maskWrEn = 1'b1; maskWrData = 8'b1100_1101; step();
    chk("R8 serOut loaded", {31'd0, serOut}, 1);
    chk("R8 mask loaded", {29'd0, maskRdData[2:0]}, 3'b101);
    maskWrData = 8'b0000_0010; step();
    chk("R8 serOut untouched", {31'd0, serOut}, 1);
    chk("R8 mask untouched", {29'd0, maskRdData[2:0]}, 3'b101);
    maskWrData = 8'b0100_1011; step();
    chk("R8 serOut cleared", {31'd0, serOut}, 0);
    chk("R8 mask reloaded", {29'd0, maskRdData[2:0]}, 3'b011);
    maskWrEn = 1'b0; maskWrData = 8'b1100_1111; step();
    chk("R8 no strobe keeps serOut", {31'd0, serOut}, 0);
    chk("R8 no strobe keeps mask", {29'd0, maskRdData[2:0]}, 3'b011);

    // R7: serial input appears in bit 7
    serIn = 1'b1; #1;
    chk("R7 serIn bit7", {31'd0, maskRdData[7]}, 1);
    serIn = 1'b0; #1;
    chk("R7 serIn bit7 low", {31'd0, maskRdData[7]}, 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule